// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

The block gathers eight interrupt request lines, ranks them by a fixed priority (level 0 highest) and raises a single interrupt line toward the processor. The processor answers with a one-cycle acknowledge strobe. In that same cycle the block places an 8-bit vector on its vector output. The vector is a programmable base plus the level number.

Software programs the block through a two-address byte port. Address 0 carries commands and address 1 carries data. An initialization command opens a short sequence of data words: vector base, cascade configuration and mode. After that, data writes load the mask register. Command bytes issue a specific end-of-interrupt or choose which internal register a command-address read returns. An optional auto end-of-interrupt mode never leaves a level marked as in service. If the request behind a raised interrupt vanishes before the acknowledge, the block answers with the level-7 vector and marks nothing as in service.

Top module: `pic_ctrl`

## Requirements
- R1: After reset, `int_req` is 0, a data-address read returns 0xFF (every level masked) and a command-address read returns the request register, which is 0x00.
- R2: A command write with bit 4 set (0x11 in use) starts initialization. It sets the mask to 0xFF and clears the request, in-service and auto-EOI state. The next three data writes are taken as base, cascade word and mode word, and none of them reaches the mask. The cascade word appears on `cfg_cascade`.
- R3: An acknowledge that serves level n presents `base + n` on `int_vector` in the acknowledge cycle.
- R4: Outside initialization, a data write loads the mask, where bit n set blocks level n. A masked level still sets its request bit but does not raise `int_req`. Clearing the mask bit lets it raise `int_req`.
- R5: `int_req` rises only for an unmasked pending level whose number is lower than every in-service level.
- R6: A request bit sets on a rising edge of its line. It clears when that line is low or when that level is served.
- R7: A serving acknowledge moves the level from the request register to the in-service register, and `int_req` is 0 in the cycle after every acknowledge.
- R8: A command write of 0x60+n clears in-service bit n and no other bit.
- R9: A command write of 0x0B selects the in-service register and 0x0A selects the request register for command-address reads. The choice holds across any number of reads.
- R10: With bit 1 of the mode word set, an acknowledge leaves the in-service register unchanged.
- R11: An acknowledge with no eligible pending level returns `base + 7` and leaves in-service bit 7 clear, even when level 7 is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 1 | 0 selects command, 1 selects data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; `bus_rdata` is valid the following cycle |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| irq_lines | input | 8 | Request lines, level 0 highest |
| int_req | output | 1 | Registered interrupt request to the processor |
| int_ack | input | 1 | One-cycle acknowledge strobe |
| int_vector | output | 8 | Vector, valid while `int_ack` is high |
| cfg_cascade | output | 8 | Stored cascade configuration word |
| cfg_auto_eoi | output | 1 | Auto end-of-interrupt mode in effect |

## Verification
The checker assumes the acknowledge strobe lasts one cycle. It also assumes that an end-of-interrupt write is never issued in the same cycle as an acknowledge, because a write and an acknowledge arriving together would let two updates touch the in-service register at once. The stimulus drives one bus operation or one acknowledge at a time and leaves idle cycles between them. It acknowledges only while `int_req` is high, except for the deliberate dropped-request case, where the line falls one cycle before the strobe.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    ST_RUN,
    ST_BASE,
    ST_CASC,
    ST_MODE
  } init_st_e;

  localparam logic [4:0] OP_SEOI_HI = 5'b01100;
  localparam logic [1:0] OP_RSEL_HI = 2'b01;
endpackage

// File: rtl/pic_cfg.sv
module pic_cfg
  import pic_pkg::*;
#(
  parameter int unsigned NUM_LVL = 8,
  parameter int unsigned BUS_W   = 8,
  localparam int unsigned LW     = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [NUM_LVL-1:0] irr,
  input  logic [NUM_LVL-1:0] isr,
  output logic [NUM_LVL-1:0] mask_q,
  output logic [BUS_W-1:0]   base_q,
  output logic [BUS_W-1:0]   casc_q,
  output logic               aeoi_q,
  output logic               busy,
  output logic               init_clr,
  output logic               eoi_vld,
  output logic [LW-1:0]      eoi_lvl
);
  init_st_e st_q;
  logic     need_mode_q, single_q, sel_isr_q;
  logic     wr_cmd, wr_dat, rsel_wr;

  assign wr_cmd   = bus_wr && !bus_addr;
  assign wr_dat   = bus_wr && bus_addr;
  assign init_clr = wr_cmd && bus_wdata[4];
  assign busy     = (st_q != ST_RUN);
  assign rsel_wr  = wr_cmd && !busy && (bus_wdata[4:3] == OP_RSEL_HI);
  assign eoi_vld  = wr_cmd && !busy && (bus_wdata[7:3] == OP_SEOI_HI);
  assign eoi_lvl  = bus_wdata[LW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_RUN;
      mask_q      <= '1;
      base_q      <= '0;
      casc_q      <= '0;
      aeoi_q      <= 1'b0;
      need_mode_q <= 1'b0;
      single_q    <= 1'b0;
      sel_isr_q   <= 1'b0;
    end else if (init_clr) begin
      st_q        <= ST_BASE;
      mask_q      <= '1;
      aeoi_q      <= 1'b0;
      need_mode_q <= bus_wdata[0];
      single_q    <= bus_wdata[1];
      sel_isr_q   <= 1'b0;
    end else if (wr_dat) begin
      case (st_q)
        ST_RUN:  mask_q <= bus_wdata[NUM_LVL-1:0];
        ST_BASE: begin
          base_q <= bus_wdata;
          if (!single_q)        st_q <= ST_CASC;
          else if (need_mode_q) st_q <= ST_MODE;
          else                  st_q <= ST_RUN;
        end
        ST_CASC: begin
          casc_q <= bus_wdata;
          st_q   <= need_mode_q ? ST_MODE : ST_RUN;
        end
        default: begin
          aeoi_q <= bus_wdata[1];
          st_q   <= ST_RUN;
        end
      endcase
    end else if (rsel_wr && bus_wdata[1]) begin
      sel_isr_q <= bus_wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      if (bus_addr)       bus_rdata <= BUS_W'(mask_q);
      else if (sel_isr_q) bus_rdata <= BUS_W'(isr);
      else                bus_rdata <= BUS_W'(irr);
    end
  end
endmodule

// File: rtl/pic_req.sv
module pic_req #(
  parameter int unsigned NUM_LVL = 8,
  localparam int unsigned LW     = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_LVL-1:0] lines,
  input  logic               clr_all,
  input  logic               take,
  input  logic [LW-1:0]      take_lvl,
  output logic [NUM_LVL-1:0] irr
);
  logic [NUM_LVL-1:0] line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
      irr    <= '0;
    end else begin
      line_q <= lines;
      for (int i = 0; i < NUM_LVL; i++) begin
        if (clr_all || !lines[i])                irr[i] <= 1'b0;
        else if (!line_q[i])                     irr[i] <= 1'b1;
        else if (take && (take_lvl == LW'(i)))   irr[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pic_find.sv
module pic_find #(
  parameter int unsigned NUM_LVL = 8,
  localparam int unsigned LW     = $clog2(NUM_LVL)
) (
  input  logic [NUM_LVL-1:0] vec,
  output logic               hit,
  output logic [LW-1:0]      idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_LVL - 1; i >= 0; i--) begin
      if (vec[i]) begin
        hit = 1'b1;
        idx = LW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_ctrl.sv
module pic_ctrl #(
  parameter int unsigned NUM_LVL = 8,
  parameter int unsigned BUS_W   = 8,
  localparam int unsigned LW     = $clog2(NUM_LVL)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [BUS_W-1:0]   bus_wdata,
  output logic [BUS_W-1:0]   bus_rdata,
  input  logic [NUM_LVL-1:0] irq_lines,
  output logic               int_req,
  input  logic               int_ack,
  output logic [BUS_W-1:0]   int_vector,
  output logic [BUS_W-1:0]   cfg_cascade,
  output logic               cfg_auto_eoi
);
  logic [NUM_LVL-1:0] irr, isr_q, mask_q, pend;
  logic [BUS_W-1:0]   base_q;
  logic               aeoi_q, busy, init_clr, eoi_vld;
  logic [LW-1:0]      eoi_lvl, p_idx, s_idx;
  logic               p_hit, s_hit, above, serve;

  pic_cfg #(.NUM_LVL(NUM_LVL), .BUS_W(BUS_W)) u_cfg (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irr(irr), .isr(isr_q),
    .mask_q(mask_q), .base_q(base_q), .casc_q(cfg_cascade), .aeoi_q(aeoi_q),
    .busy(busy), .init_clr(init_clr), .eoi_vld(eoi_vld), .eoi_lvl(eoi_lvl)
  );

  pic_req #(.NUM_LVL(NUM_LVL)) u_req (
    .clk(clk), .rst(rst), .lines(irq_lines), .clr_all(init_clr),
    .take(serve), .take_lvl(p_idx), .irr(irr)
  );

  assign pend = irr & ~mask_q;

  pic_find #(.NUM_LVL(NUM_LVL)) u_find_pend (.vec(pend),  .hit(p_hit), .idx(p_idx));
  pic_find #(.NUM_LVL(NUM_LVL)) u_find_serv (.vec(isr_q), .hit(s_hit), .idx(s_idx));

  assign above        = p_hit && (!s_hit || (p_idx < s_idx));
  assign serve        = int_ack && above;
  assign int_vector   = base_q + (serve ? BUS_W'(p_idx) : BUS_W'(NUM_LVL - 1));
  assign cfg_auto_eoi = aeoi_q;

  always_ff @(posedge clk) begin
    if (rst || init_clr) begin
      isr_q <= '0;
    end else begin
      for (int i = 0; i < NUM_LVL; i++) begin
        if (serve && !aeoi_q && (p_idx == LW'(i)))  isr_q[i] <= 1'b1;
        else if (eoi_vld && (eoi_lvl == LW'(i)))    isr_q[i] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || int_ack || busy) int_req <= 1'b0;
    else                        int_req <= above;
  end
endmodule

// File: rtl/pic_ctrl_chk.sv
module pic_ctrl_chk #(
  parameter int unsigned NUM_LVL = 8,
  parameter int unsigned BUS_W   = 8,
  localparam int unsigned LW     = $clog2(NUM_LVL)
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_addr,
  input logic               bus_wr,
  input logic [BUS_W-1:0]   bus_wdata,
  input logic               int_req,
  input logic               int_ack,
  input logic [NUM_LVL-1:0] isr,
  input logic [NUM_LVL-1:0] mask,
  input logic               aeoi,
  input logic               serve,
  input logic [LW-1:0]      lvl
);
  assert_mask_reset_R1: assert property (@(posedge clk)
    rst |=> (mask == '1));

  assert_ack_drops_int_R7: assert property (@(posedge clk) disable iff (rst)
    int_ack |=> !int_req);

  assert_ack_sets_isr_R7: assert property (@(posedge clk) disable iff (rst)
    (serve && !aeoi && !bus_wr) |=> isr[$past(lvl)]);

  assert_eoi_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && !bus_addr && (bus_wdata[7:3] == 5'b01100) && !int_ack)
      |=> !isr[$past(bus_wdata[LW-1:0])]);

  assert_aeoi_keeps_isr_R10: assert property (@(posedge clk) disable iff (rst)
    (int_ack && aeoi && !bus_wr) |=> (isr == $past(isr)));

  assert_spurious_keeps_isr_R11: assert property (@(posedge clk) disable iff (rst)
    (int_ack && !serve && !bus_wr) |=> (isr == $past(isr)));
endmodule

bind pic_ctrl pic_ctrl_chk #(.NUM_LVL(NUM_LVL), .BUS_W(BUS_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .int_req(int_req), .int_ack(int_ack), .isr(isr_q), .mask(mask_q),
  .aeoi(aeoi_q), .serve(serve), .lvl(p_idx)
);

// File: tb/test_pic_ctrl.sv
module test_pic_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_addr = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0, int_ack = 1'b0;
  logic [7:0] bus_wdata = '0, irq_lines = '0;
  logic [7:0] bus_rdata, int_vector, cfg_cascade;
  logic       int_req, cfg_auto_eoi;

  int   n_chk = 0, n_fail = 0;
  bit   rd_pend = 0, done = 0;
  logic [7:0] exp_val[$];
  string      exp_tag[$];

  pic_ctrl i_pic_ctrl (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
    .int_req(int_req), .int_ack(int_ack), .int_vector(int_vector),
    .cfg_cascade(cfg_cascade), .cfg_auto_eoi(cfg_auto_eoi)
  );

  always #2 clk = ~clk;

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: pops expectations as read data and vectors appear
  always @(negedge clk) begin
    if (rd_pend) begin
      rd_pend = 0;
      chk(exp_tag.pop_front(), bus_rdata, exp_val.pop_front());
    end
    if (int_ack) chk(exp_tag.pop_front(), int_vector, exp_val.pop_front());
    if (bus_rd) rd_pend = 1;
  end

  task automatic idle(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wr(logic a, logic [7:0] d);
    @(posedge clk); #1;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic a, logic [7:0] exp, string tag);
    @(posedge clk); #1;
    exp_val.push_back(exp); exp_tag.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic ack(logic [7:0] exp, string tag);
    @(posedge clk); #1;
    exp_val.push_back(exp); exp_tag.push_back(tag);
    int_ack = 1'b1;
    @(posedge clk); #1;
    int_ack = 1'b0;
  endtask

  task automatic line(int n, logic v);
    @(posedge clk); #1;
    irq_lines[n] = v;
  endtask

  task automatic chk_int(logic exp, string tag);
    @(negedge clk);
    chk(tag, {7'd0, int_req}, {7'd0, exp});
  endtask

  task automatic init(logic [7:0] base, logic [7:0] casc, logic [7:0] mode);
    wr(0, 8'h11); wr(1, base); wr(1, casc); wr(1, mode);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    idle(3); #1; rst = 1'b0;
    chk_int(0, "R1 int after reset");
    rd(1, 8'hFF, "R1 mask after reset");
    rd(0, 8'h00, "R1 request reg after reset");

    init(8'h20, 8'h04, 8'h01);
    chk("R2 cascade word", cfg_cascade, 8'h04);
    chk("R2 normal eoi mode", {7'd0, cfg_auto_eoi}, 8'h00);
    rd(1, 8'hFF, "R2 init words kept out of mask");

    wr(1, 8'h00);
    line(3, 1); idle(3);
    chk_int(1, "R6 edge raises int");
    ack(8'h23, "R3 vector level 3");
    chk_int(0, "R7 int low after ack");
    wr(0, 8'h0B);
    rd(0, 8'h08, "R7 level 3 in service");
    rd(0, 8'h08, "R9 isr select persists");
    wr(0, 8'h0A);
    rd(0, 8'h00, "R7 request moved out");

    line(5, 1); idle(3);
    chk_int(0, "R5 lower level blocked by in-service");
    line(1, 1); idle(3);
    chk_int(1, "R5 higher level preempts");
    ack(8'h21, "R3 vector level 1");
    wr(0, 8'h0B);
    rd(0, 8'h0A, "R7 nested in service");
    wr(0, 8'h61);
    rd(0, 8'h08, "R8 eoi clears only bit 1");
    idle(2);
    chk_int(0, "R5 level 5 still blocked");
    wr(0, 8'h63); idle(3);
    chk_int(1, "R8 eoi releases level 5");
    ack(8'h25, "R3 vector level 5");
    wr(0, 8'h65);
    rd(0, 8'h00, "R8 all cleared");

    line(1, 0); line(3, 0); line(5, 0);
    wr(1, 8'h40);
    line(6, 1); idle(3);
    chk_int(0, "R4 masked level silent");
    wr(0, 8'h0A);
    rd(0, 8'h40, "R4 masked request latched");
    rd(1, 8'h40, "R4 mask readback");
    wr(1, 8'h00); idle(3);
    chk_int(1, "R4 unmask raises int");
    ack(8'h26, "R3 vector level 6");
    wr(0, 8'h66);
    line(6, 0);
    line(3, 1); idle(2); line(3, 0); idle(2);
    rd(0, 8'h00, "R6 request clears when line falls");

    wr(1, 8'h80);
    line(2, 1); idle(3);
    chk_int(1, "R11 level 2 raised");
    line(2, 0);
    ack(8'h27, "R11 spurious vector with level 7 masked");
    wr(0, 8'h0B);
    rd(0, 8'h00, "R11 no in-service bit");

    wr(1, 8'h00);
    line(0, 1); idle(3);
    ack(8'h20, "R3 vector level 0");
    line(0, 0);
    init(8'h48, 8'h02, 8'h03);
    chk("R2 cascade word rewritten", cfg_cascade, 8'h02);
    chk("R10 auto eoi mode", {7'd0, cfg_auto_eoi}, 8'h01);
    rd(1, 8'hFF, "R2 init remasks all");
    wr(0, 8'h0B);
    rd(0, 8'h00, "R2 init clears in-service");
    wr(1, 8'h00);
    line(4, 1); idle(3);
    chk_int(1, "R10 level 4 raised");
    ack(8'h4C, "R3 vector with new base");
    rd(0, 8'h00, "R10 auto eoi leaves isr clear");
    idle(2);
    chk_int(0, "R7 no retrigger without new edge");

    idle(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule